// File: doc/BRIEF.md
# Flash Access Control Register

This block is an 8-bit control register on a microcontroller's special-function-register bus. It decides how the processor may reach its on-chip program flash. It holds a program-write mode. While that mode is on, stores to external data space go into flash instead of data RAM. It also holds an arm bit for a whole-array erase and a one-way security lock. The lock stops external debug reads of flash and of the coprocessor RAM. It reports whether the boot loader's preboot phase is still active.

The register decodes a single bus address. A write strobe loads it, and reads return the value combinationally on the same address. Three small state machines hold its writable state:

- The write-mode machine has the states `WR_OFF` and `WR_ON`.
  - `WR_OFF -> WR_ON` on an accepted write of 1.
  - `WR_ON -> WR_OFF` on a byte-written pulse or on an accepted write of 0.
  - A write is accepted only while interrupts are globally disabled.
- The erase machine has the states `ER_IDLE` and `ER_ARMED`.
  - `ER_IDLE -> ER_ARMED` on a write of 1.
  - `ER_ARMED -> ER_IDLE` on an erase-start pulse or on a write of 0.
  - Every erase therefore needs a fresh write.
- The security machine has the states `SEC_OPEN` and `SEC_LOCKED`.
  - `SEC_OPEN -> SEC_LOCKED` on a write of 1.
  - No transition leaves `SEC_LOCKED` except reset.

The register updates on the rising clock edge and uses a synchronous, active-high reset.

Top module: `flash_ctl_sfr`

## Requirements
- R1: While `rst` is high at a clock edge, all three machines return to their off states after that edge: `pgm_wr_en`, `mass_erase_en` and `secure_lock` are 0.
- R2: The register answers only at bus address 0xB2. A write strobe at any other address changes nothing. `sfr_rdata` is 0 whenever `sfr_addr` is not 0xB2.
- R3: While `irq_global_en` is 0, a write to 0xB2 loads data bit 0 into the program-write mode. That mode drives `pgm_wr_en` and reads back in `sfr_rdata[0]`.
- R4: While `irq_global_en` is 1, a write to 0xB2 leaves the program-write mode unchanged, whatever value data bit 0 carries.
- R5: A `byte_done` pulse clears the program-write mode at that edge. This takes priority over a write of 1 in the same cycle.
- R6: A write to 0xB2 loads data bit 1 into the erase arm, which drives `mass_erase_en`. This write is not gated by `irq_global_en`. `sfr_rdata[1]` always reads 0.
- R7: An `erase_start` pulse clears the erase arm at that edge. This takes priority over a write of 1 in the same cycle.
- R8: Writing 1 in data bit 6 sets `secure_lock`, and it reads back in `sfr_rdata[6]`. Writing 0 there has no effect. Only reset clears it.
- R9: `sfr_rdata[7]` follows `preboot_active` in the same cycle. Writes to data bit 7 have no effect.
- R10: `sfr_rdata[5:2]` always read 0, whatever was written to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wdata | input | 8 | SFR bus write data |
| sfr_we | input | 1 | SFR bus write strobe |
| sfr_rdata | output | 8 | SFR bus read data, combinational |
| byte_done | input | 1 | Pulse from the flash controller: one byte has been programmed |
| erase_start | input | 1 | Pulse from the flash controller: a mass erase has begun |
| irq_global_en | input | 1 | Global interrupt-enable state of the processor |
| preboot_active | input | 1 | High while the preboot sequence runs |
| pgm_wr_en | output | 1 | Routes external-data stores into flash |
| mass_erase_en | output | 1 | Arms one mass erase |
| secure_lock | output | 1 | Blocks external debug reads of flash and coprocessor RAM |

## Verification
The hardest cases to bring about are the collisions. In one, a write of 1 to the write-mode bit lands in the very cycle that the flash controller reports a finished byte. In the other, an erase is re-armed in the same cycle as an erase-start pulse. Both are corner cases of priority that normal firmware rarely hits. The stimulus drives the bus write and the controller pulse on the same clock edge and expects the clear to win. It reaches the interrupt gate by holding the interrupt-enable input high while the write-mode bit is set, and again while it is clear, so that neither a write of 0 nor a write of 1 is allowed to pass.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
    parameter int          REG_W    = 8;
    parameter int          ADR_W    = 8;
    parameter logic [7:0]  CTL_ADDR = 8'hB2;

    // Bit positions decoded by software
    parameter int BIT_PGM    = 0;
    parameter int BIT_ERASE  = 1;
    parameter int BIT_SECURE = 6;
    parameter int BIT_BOOT   = 7;

    typedef enum logic {WR_OFF, WR_ON}       wr_state_t;
    typedef enum logic {ER_IDLE, ER_ARMED}   er_state_t;
    typedef enum logic {SEC_OPEN, SEC_LOCKED} sec_state_t;
endpackage

// File: rtl/flash_wr_fsm.sv
module flash_wr_fsm
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic irq_en,
    input  logic byte_done,
    output logic mode_on
);
    wr_state_t state_q, state_d;
    logic      accept;

    assign accept = wr_hit && !irq_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_OFF: if (accept && wr_bit && !byte_done) state_d = WR_ON;
            WR_ON:  if (byte_done || (accept && !wr_bit)) state_d = WR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WR_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        mode_on = (state_q == WR_ON);
    end
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic erase_start,
    output logic armed
);
    er_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ER_IDLE:  if (wr_hit && wr_bit && !erase_start) state_d = ER_ARMED;
            ER_ARMED: if (erase_start || (wr_hit && !wr_bit)) state_d = ER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ER_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == ER_ARMED);
    end
endmodule

// File: rtl/flash_secure_fsm.sv
module flash_secure_fsm
    import flash_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic locked
);
    sec_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEC_OPEN:   if (wr_hit && wr_bit) state_d = SEC_LOCKED;
            SEC_LOCKED: state_d = SEC_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEC_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        locked = (state_q == SEC_LOCKED);
    end
endmodule

// File: rtl/flash_ctl_sfr.sv
module flash_ctl_sfr
    import flash_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ADR_W-1:0] sfr_addr,
    input  logic [REG_W-1:0] sfr_wdata,
    input  logic             sfr_we,
    output logic [REG_W-1:0] sfr_rdata,
    input  logic             byte_done,
    input  logic             erase_start,
    input  logic             irq_global_en,
    input  logic             preboot_active,
    output logic             pgm_wr_en,
    output logic             mass_erase_en,
    output logic             secure_lock
);
    logic sel;
    logic wr_hit;

    assign sel    = (sfr_addr == CTL_ADDR);
    assign wr_hit = sel && sfr_we;

    flash_wr_fsm u_wr (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .wr_bit    (sfr_wdata[BIT_PGM]),
        .irq_en    (irq_global_en),
        .byte_done (byte_done),
        .mode_on   (pgm_wr_en)
    );

    flash_erase_fsm u_er (
        .clk         (clk),
        .rst         (rst),
        .wr_hit      (wr_hit),
        .wr_bit      (sfr_wdata[BIT_ERASE]),
        .erase_start (erase_start),
        .armed       (mass_erase_en)
    );

    flash_secure_fsm u_sec (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr_bit (sfr_wdata[BIT_SECURE]),
        .locked (secure_lock)
    );

    // Read view: erase arm is write-only, unused bits read 0
    always_comb begin
        sfr_rdata = '0;
        if (sel) begin
            sfr_rdata[BIT_PGM]    = pgm_wr_en;
            sfr_rdata[BIT_SECURE] = secure_lock;
            sfr_rdata[BIT_BOOT]   = preboot_active;
        end
    end
endmodule

// File: rtl/flash_ctl_sfr_chk.sv
module flash_ctl_sfr_chk
    import flash_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [ADR_W-1:0] sfr_addr,
    input logic [REG_W-1:0] sfr_wdata,
    input logic             sfr_we,
    input logic [REG_W-1:0] sfr_rdata,
    input logic             byte_done,
    input logic             erase_start,
    input logic             irq_global_en,
    input logic             preboot_active,
    input logic             pgm_wr_en,
    input logic             mass_erase_en,
    input logic             secure_lock
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!pgm_wr_en && !mass_erase_en && !secure_lock));

    // R2
    other_addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr != CTL_ADDR) |-> (sfr_rdata == '0));

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_global_en && !byte_done) |=> (pgm_wr_en == $past(pgm_wr_en)));

    // R5
    byte_autoclear_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !pgm_wr_en);

    // R7
    erase_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !mass_erase_en);

    // R8
    secure_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        secure_lock |=> secure_lock);

    // R9
    boot_view_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == CTL_ADDR) |-> (sfr_rdata[BIT_BOOT] == preboot_active));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sfr_rdata[5:1] == 5'b0));
endmodule

bind flash_ctl_sfr flash_ctl_sfr_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .sfr_addr       (sfr_addr),
    .sfr_wdata      (sfr_wdata),
    .sfr_we         (sfr_we),
    .sfr_rdata      (sfr_rdata),
    .byte_done      (byte_done),
    .erase_start    (erase_start),
    .irq_global_en  (irq_global_en),
    .preboot_active (preboot_active),
    .pgm_wr_en      (pgm_wr_en),
    .mass_erase_en  (mass_erase_en),
    .secure_lock    (secure_lock)
);

// File: tb/tb_flash_ctl_sfr.sv
module tb_flash_ctl_sfr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       byte_done = 1'b0;
    logic       erase_start = 1'b0;
    logic       irq_global_en = 1'b0;
    logic       preboot_active = 1'b0;
    logic       pgm_wr_en;
    logic       mass_erase_en;
    logic       secure_lock;

    always #10 clk = ~clk;

    flash_ctl_sfr dut (.*);

    typedef struct {
        logic [7:0] rdata;
        logic       pgm;
        logic       er;
        logic       sec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Model of the requirements
    logic m_pgm = 1'b0, m_er = 1'b0, m_sec = 1'b0;

    task automatic op(input logic r, input logic [7:0] a, input logic [7:0] d,
                      input logic we, input logic irq, input logic bd,
                      input logic es, input logic pre, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        rst = r; sfr_addr = a; sfr_wdata = d; sfr_we = we;
        irq_global_en = irq; byte_done = bd; erase_start = es;
        preboot_active = pre;
        hit = we && (a == 8'hB2);
        if (r) begin
            m_pgm = 0; m_er = 0; m_sec = 0;
        end else begin
            if (bd)              m_pgm = 0;
            else if (hit && !irq) m_pgm = d[0];
            if (es)       m_er = 0;
            else if (hit) m_er = d[1];
            if (hit && d[6]) m_sec = 1;
        end
        e.rdata = (a == 8'hB2) ? {pre, m_sec, 5'b0, m_pgm} : 8'h00;
        e.pgm = m_pgm; e.er = m_er; e.sec = m_sec; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [10:0] act, want;
            e = exp_q.pop_front();
            act  = {sfr_rdata, pgm_wr_en, mass_erase_en, secure_lock};
            want = {e.rdata, e.pgm, e.er, e.sec};
            n_checks++;
            if (act !== want) begin
                n_fail++;
                $display("FAIL %s: rdata/pgm/er/sec actual %h/%b/%b/%b expected %h/%b/%b/%b",
                         e.tag, sfr_rdata, pgm_wr_en, mass_erase_en, secure_lock,
                         e.rdata, e.pgm, e.er, e.sec);
            end
        end
    end

    initial begin
        op(1, 8'hB2, 8'h00, 0, 0, 0, 0, 0, "R1 reset");
        op(1, 8'hB2, 8'h00, 0, 0, 0, 0, 0, "R1 reset hold");
        op(0, 8'hB2, 8'h01, 1, 0, 0, 0, 0, "R3 set write mode");
        op(0, 8'hB3, 8'h00, 1, 0, 0, 0, 0, "R2 other address write");
        op(0, 8'hB2, 8'h00, 0, 0, 0, 0, 1, "R9 preboot visible");
        op(0, 8'hB2, 8'h00, 1, 1, 0, 0, 1, "R4 clear blocked by irq");
        op(0, 8'hB2, 8'h00, 0, 1, 1, 0, 0, "R5 byte done clears");
        op(0, 8'hB2, 8'h01, 1, 1, 0, 0, 0, "R4 set blocked by irq");
        op(0, 8'hB2, 8'h01, 1, 0, 1, 0, 0, "R5 byte done beats write");
        op(0, 8'hB2, 8'h01, 1, 0, 0, 0, 0, "R3 set again");
        op(0, 8'hB2, 8'h00, 1, 0, 0, 0, 0, "R3 clear by write");
        op(0, 8'hB2, 8'h02, 1, 1, 0, 0, 0, "R6 erase arm, reads 0");
        op(0, 8'hB2, 8'h3C, 1, 0, 0, 0, 0, "R10 unused bits / R6 disarm");
        op(0, 8'hB2, 8'h02, 1, 0, 0, 0, 0, "R6 arm");
        op(0, 8'hB2, 8'h00, 0, 0, 0, 1, 0, "R7 erase start clears");
        op(0, 8'hB2, 8'h02, 1, 0, 0, 1, 0, "R7 erase start beats write");
        op(0, 8'hB2, 8'h40, 1, 0, 0, 0, 0, "R8 lock");
        op(0, 8'hB2, 8'h00, 1, 0, 0, 0, 0, "R8 write 0 ignored");
        op(0, 8'h10, 8'h00, 0, 0, 0, 0, 1, "R2 read other address");
        op(0, 8'hB2, 8'h80, 1, 0, 0, 0, 0, "R9 bit7 write ignored");
        op(1, 8'hB2, 8'h00, 0, 0, 0, 0, 0, "R1 reset clears lock");
        op(0, 8'hB2, 8'h00, 0, 0, 0, 0, 0, "R1 after reset");
        @(negedge clk);
        sfr_we = 0; byte_done = 0; erase_start = 0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule